// File: doc/BRIEF.md
# Buffered Serial Transmitter Channel

This block turns parallel characters into an asynchronous serial frame on a single output line. A one-character holding register sits in front of the frame shifter, so software can queue the next character while the current one is still on the line. A flag reports whether the holding register can take a new character. An interrupt output, gated by an enable, follows that flag.

The character format is selected by static configuration inputs. These come from a control register outside the block. A character is 7 or 8 bits long and is sent least- or most-significant bit first. An even or odd parity bit may follow the data, and one or two stop bits close the frame. Bit timing comes from an external baud tick, and each serial bit lasts a fixed number of ticks. The format is latched when a character moves into the shifter.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset the line is high, `tx_empty` is 1 and `tx_irq` is 0 while the interrupt enable is 0.
- R2: A write strobe while `tx_empty` is 1 stores `wr_data` and drives `tx_empty` to 0 in the following cycle.
- R3: A write strobe while `tx_empty` is 0 has no effect: the character already held is the one later transmitted.
- R4: While `cfg_tx_en` is 0 a held character stays held, `tx_empty` stays 0 and the line stays high. When `cfg_tx_en` is 1 and the shifter is idle, the held character moves to the shifter and `tx_empty` returns to 1 one cycle later.
- R5: The start bit begins at the first baud tick after the move into the shifter. Every bit lasts 16 baud ticks, and the line changes only in the cycle that follows a baud tick.
- R6: A frame is a low start bit, the data bits, an optional parity bit and then one or two high stop bits. Between frames the line idles high.
- R7: With `cfg_msb_first` 0, data bit 0 is sent first. With `cfg_msb_first` 1, the highest used data bit is sent first.
- R8: With `cfg_len8` 0 only bits 6..0 are sent, in either order, and bit 7 of the written data never reaches the line.
- R9: With `cfg_par_en` 1 a parity bit follows the last data bit. With `cfg_par_odd` 0 the data bits plus the parity bit hold an even number of ones; with `cfg_par_odd` 1 they hold an odd number.
- R10: `cfg_two_stop` 1 adds a second stop bit, so that back-to-back frames start (1 + data + parity + stops) x 16 ticks apart, plus at most one tick.
- R11: `tx_irq` is 1 exactly when `tx_empty` and `cfg_irq_en` are both 1, including immediately after reset.
- R12: A character written while a frame is on the line is held with `tx_empty` 0 until that frame ends. It is then sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to queue |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_len8 | input | 1 | 1: 8-bit characters, 0: 7-bit characters |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_irq_en | input | 1 | Transmit interrupt enable |
| tx_line | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Holding register can accept a character |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The hardest state to reach is a second character waiting in the holding register while the first one is mid-frame. In that state the empty flag must stay low for hundreds of cycles and then rise at the frame boundary. The bench reaches it by running a capture process and a writer side by side. The writer queues the second character as soon as the first has moved into the shifter. The capture process then checks both frames bit by bit and the spacing between their start edges. A separate scenario queues a character with transmit disabled and then strobes a second write, so the dropped write can only show up in the frame later seen on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic len8;
      logic msb_first;
      logic par_en;
      logic par_odd;
      logic two_stop;
   } tx_fmt_t;
endpackage

// File: rtl/utx_hold_reg.sv
module utx_hold_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output logic [DATA_W-1:0] data_q,
   output logic              empty_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         empty_q <= 1'b1;
      end else if (wr_en && empty_q) begin
         data_q  <= wr_data;
         empty_q <= 1'b0;
      end else if (load) begin
         empty_q <= 1'b1;
      end
   end

   p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && empty_q |=> !empty_q);
   p_full_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !empty_q |=> $stable(data_q));
   p_load_refills_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load && !empty_q |=> empty_q);
endmodule

// File: rtl/utx_frame_build.sv
module utx_frame_build
   import uart_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = DATA_W + 4,
   parameter int CNT_W   = 4
) (
   input  logic [DATA_W-1:0]  data_i,
   input  tx_fmt_t            fmt,
   output logic [FRAME_W-1:0] frame_o,
   output logic [CNT_W-1:0]   nbits_o
);
   logic [DATA_W-1:0] rev_full, rev_short, masked, ordered;
   logic [DATA_W:0]   ord_ext;
   logic              par_bit;
   int                n_used;

   for (genvar g = 0; g < DATA_W; g++) begin : g_rev
      assign rev_full[g] = data_i[DATA_W-1-g];
      if (g < DATA_W - 1) begin : g_s
         assign rev_short[g] = data_i[DATA_W-2-g];
      end else begin : g_z
         assign rev_short[g] = 1'b0;
      end
   end

   assign masked  = fmt.len8 ? data_i : {1'b0, data_i[DATA_W-2:0]};
   assign ordered = fmt.msb_first ? (fmt.len8 ? rev_full : rev_short) : masked;
   assign ord_ext = {1'b0, ordered};
   assign par_bit = (^masked) ^ fmt.par_odd;
   assign n_used  = fmt.len8 ? DATA_W : DATA_W - 1;

   always_comb begin
      frame_o    = '1;
      frame_o[0] = 1'b0;
      for (int i = 0; i <= DATA_W; i++) begin
         if (i < n_used) begin
            frame_o[1+i] = ord_ext[i];
         end else if (i == n_used && fmt.par_en) begin
            frame_o[1+i] = par_bit;
         end
      end
      nbits_o = CNT_W'(1 + n_used + int'(fmt.par_en) + (fmt.two_stop ? 2 : 1));
   end
endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic baud_tick,
   output logic bit_end
);
   localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS_PER_BIT - 1);

   logic [TICK_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (baud_tick) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign bit_end = run && baud_tick && (cnt_q == LAST);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
   import uart_tx_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              baud_tick,
   input  logic              cfg_tx_en,
   input  logic              cfg_len8,
   input  logic              cfg_msb_first,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              cfg_irq_en,
   output logic              tx_line,
   output logic              tx_empty,
   output logic              tx_irq
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("DATA_W must lie between 5 and 9");
   end
   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be at least 2");
   end

   tx_state_e          state_q;
   logic [FRAME_W-1:0] shreg_q, frame_w;
   logic [CNT_W-1:0]   left_q, nbits_w;
   logic [DATA_W-1:0]  held_w;
   logic               line_q, load, bit_end;
   tx_fmt_t            fmt;

   assign fmt  = '{len8: cfg_len8, msb_first: cfg_msb_first, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};
   assign load = (state_q == ST_IDLE) && cfg_tx_en && !tx_empty;

   utx_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .load(load), .data_q(held_w), .empty_q(tx_empty)
   );

   utx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
      .data_i(held_w), .fmt(fmt), .frame_o(frame_w), .nbits_o(nbits_w)
   );

   utx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state_q == ST_SEND),
      .baud_tick(baud_tick), .bit_end(bit_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg_q <= '1;
         left_q  <= '0;
         line_q  <= 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (load) begin
                  shreg_q <= frame_w;
                  left_q  <= nbits_w;
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (baud_tick) begin
                  line_q  <= shreg_q[0];
                  state_q <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (bit_end) begin
                  if (left_q == CNT_W'(1)) begin
                     line_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     line_q  <= shreg_q[1];
                     shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                     left_q  <= left_q - 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tx_line = line_q;
   assign tx_irq  = tx_empty && cfg_irq_en;

   p_line_moves_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_q) |-> $past(baud_tick));
   p_idle_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> line_q);
   p_send_keeps_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND) && !bit_end |=> $stable(left_q));
endmodule

// File: tb/tb_uart_tx_chan.sv
module tb_uart_tx_chan;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       baud_tick = 1'b0;
   logic       cfg_tx_en = 1'b0, cfg_len8 = 1'b1, cfg_msb_first = 1'b0;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
   logic       cfg_irq_en = 1'b0;
   logic       tx_line, tx_empty, tx_irq;
   int         checks = 0, errors = 0, cyc = 0, tdiv = 0;

   localparam int TDIV = 4;
   localparam int BITCLK = 16 * TDIV;

   uart_tx_chan dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .baud_tick(baud_tick), .cfg_tx_en(cfg_tx_en), .cfg_len8(cfg_len8),
      .cfg_msb_first(cfg_msb_first), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
      .cfg_irq_en(cfg_irq_en), .tx_line(tx_line), .tx_empty(tx_empty), .tx_irq(tx_irq)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      tdiv      <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == TDIV - 1);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_char(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_fmt(input bit len8, input bit msb, input bit par, input bit odd, input bit two);
      cfg_len8 = len8; cfg_msb_first = msb; cfg_par_en = par;
      cfg_par_odd = odd; cfg_two_stop = two;
   endtask

   function automatic void model(input logic [7:0] d, output logic [11:0] bits, output int nb);
      int n = cfg_len8 ? 8 : 7;
      int idx = 1;
      int ones = 0;
      bits = '1;
      bits[0] = 1'b0;
      for (int i = 0; i < n; i++) begin
         logic b = cfg_msb_first ? d[n-1-i] : d[i];
         bits[idx] = b; idx++; ones += int'(b);
      end
      if (cfg_par_en) begin
         bits[idx] = ones[0] ^ cfg_par_odd; idx++;
      end
      nb = idx + (cfg_two_stop ? 2 : 1);
   endfunction

   task automatic get_frame(input int nb, output logic [11:0] bits, output int t0);
      do @(negedge clk); while (tx_line !== 1'b0);
      t0 = cyc;
      bits = '1;
      repeat (BITCLK / 2) @(negedge clk);
      bits[0] = tx_line;
      for (int i = 1; i < nb; i++) begin
         repeat (BITCLK) @(negedge clk);
         bits[i] = tx_line;
      end
   endtask

   task automatic send_and_check(input logic [7:0] d, input string req);
      logic [11:0] exp_b, got_b, mask;
      int nb, t0;
      model(d, exp_b, nb);
      write_char(d);
      get_frame(nb, got_b, t0);
      mask = 12'((1 << nb) - 1);
      check((got_b & mask) == (exp_b & mask), req, int'(got_b & mask), int'(exp_b & mask));
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic t_reset;
      check(tx_line === 1'b1, "R1 idle line", int'(tx_line), 1);
      check(tx_empty === 1'b1, "R1 empty after reset", int'(tx_empty), 1);
      check(tx_irq === 1'b0, "R1 irq off", int'(tx_irq), 0);
      cfg_irq_en = 1'b1;
      @(negedge clk);
      check(tx_irq === 1'b1, "R11 irq at once", int'(tx_irq), 1);
   endtask

   task automatic t_hold_disabled;
      logic [11:0] exp_b, got_b;
      int nb, t0;
      set_fmt(1, 0, 0, 0, 0);
      cfg_tx_en = 1'b0;
      write_char(8'h5A);
      check(tx_empty === 1'b0, "R2 empty cleared", int'(tx_empty), 0);
      check(tx_irq === 1'b0, "R11 irq follows empty", int'(tx_irq), 0);
      write_char(8'h33);
      repeat (100) @(negedge clk);
      check(tx_empty === 1'b0, "R4 held while disabled", int'(tx_empty), 0);
      check(tx_line === 1'b1, "R4 line idle while disabled", int'(tx_line), 1);
      cfg_tx_en = 1'b1;
      @(negedge clk);
      check(tx_empty === 1'b1, "R4 empty after move", int'(tx_empty), 1);
      check(tx_irq === 1'b1, "R11 irq back", int'(tx_irq), 1);
      model(8'h5A, exp_b, nb);
      get_frame(nb, got_b, t0);
      check(got_b[9:0] == exp_b[9:0], "R3 ignored write kept data", int'(got_b[9:0]), int'(exp_b[9:0]));
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic t_start_len;
      int lows = 0;
      set_fmt(1, 0, 0, 0, 0);
      write_char(8'hFF);
      do @(negedge clk); while (tx_line !== 1'b0);
      while (tx_line === 1'b0) begin
         lows++;
         @(negedge clk);
      end
      check(lows == BITCLK, "R5 start bit length", lows, BITCLK);
      repeat (10 * BITCLK) @(negedge clk);
   endtask

   task automatic t_formats;
      set_fmt(1, 0, 0, 0, 0); send_and_check(8'hC1, "R6 R7 lsb first 8N1");
      set_fmt(1, 1, 0, 0, 0); send_and_check(8'hC1, "R7 msb first");
      set_fmt(0, 0, 0, 0, 0); send_and_check(8'h80, "R8 7-bit lsb drops bit7");
      set_fmt(0, 1, 0, 0, 0); send_and_check(8'hC1, "R8 7-bit msb starts at bit6");
      set_fmt(1, 0, 1, 0, 0); send_and_check(8'h07, "R9 even parity");
      set_fmt(1, 0, 1, 1, 0); send_and_check(8'h07, "R9 odd parity");
      set_fmt(0, 1, 1, 0, 0); send_and_check(8'hFF, "R8 R9 7-bit even parity");
   endtask

   task automatic t_back_to_back(input bit two, input bit par);
      logic [11:0] ea, eb, ga, gb, mask;
      int nb, ta, tb;
      set_fmt(1, 0, par, 0, two);
      model(8'h96, ea, nb);
      model(8'h3C, eb, nb);
      mask = 12'((1 << nb) - 1);
      fork
         begin
            get_frame(nb, ga, ta);
            get_frame(nb, gb, tb);
         end
         begin
            write_char(8'h96);
            @(negedge clk);
            write_char(8'h3C);
            check(tx_empty === 1'b0, "R12 second char held", int'(tx_empty), 0);
            repeat (5 * BITCLK) @(negedge clk);
            check(tx_empty === 1'b0, "R12 empty low mid-frame", int'(tx_empty), 0);
         end
      join
      check((ga & mask) == (ea & mask), "R12 first frame", int'(ga & mask), int'(ea & mask));
      check((gb & mask) == (eb & mask), "R12 queued frame", int'(gb & mask), int'(eb & mask));
      check((tb - ta) >= nb * BITCLK && (tb - ta) <= nb * BITCLK + 2 * TDIV,
            two ? "R10 two stop spacing" : "R10 one stop spacing", tb - ta, nb * BITCLK);
      repeat (BITCLK) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hold_disabled();
      t_start_len();
      t_formats();
      t_back_to_back(1'b0, 1'b0);
      t_back_to_back(1'b1, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule